// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block sits between up to six raw, asynchronous interrupt pins and an interrupt control unit. Each pin is brought into the clock domain through a two-flop synchroniser. A per-pin trigger code then decides whether the pin reacts to a rising edge, a falling edge, either edge, a high level, a low level, or nothing. Edge events are latched in a pending register until software clears them. Level modes drive the request straight from the synchronised pin. An enable register gates every pin's request line toward the interrupt controller.

Software reaches the block over a plain single-cycle 32-bit register bus. There are four word slots: the trigger configuration, a spare control word, pending and enable. The bus has no back-pressure. A write takes effect at the clock edge where select and write are both high. Read data is combinational and valid while select is high and write is low, and it reads zero otherwise. The usual bring-up for a pin is to write low-level mode into its field, write a 0 to its pending bit, and then set its enable bit.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every register reads zero and every request output is low.
- R2: With trigger code 1 (rising), a 0-to-1 change on the synchronised pin sets the pin's pending bit three clock edges after the pin changes. The bit stays set after the pin returns low.
- R3: With trigger code 2 (falling), only a 1-to-0 change sets the pending bit.
- R4: With trigger code 3 (both), a change in either direction sets the pending bit.
- R5: With trigger code 5 (high level), the request follows the synchronised pin high level and never sets the pending bit.
- R6: With trigger code 6 (low level), the request follows the synchronised pin low level and never sets the pending bit.
- R7: Trigger codes 0, 4 and 7 produce neither a pending event nor a level request.
- R8: A write to word 2 (pending) clears each pin bit i where data bit i is 0 and leaves the bits that are written 1. An edge event in the same cycle wins over a clear.
- R9: The request for pin i is high only when enable bit i (word 3, bit i) is set. Pending bits still latch while the pin is disabled.
- R10: Word 1 reads as zero, and writes to it change no register.
- R11: In word 0, pin i's trigger code is held in bits [4i+2:4i]. Bit 4i+3 and all bits above the last pin read zero, and writes to those bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index: 0 config, 1 spare, 2 pending, 3 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pin_in | input | NUM_PINS | Raw asynchronous interrupt pins |
| irq_req | output | NUM_PINS | Per-pin request toward the interrupt controller |

## Verification
The hardest case to reach is a pending clear that lands on the same clock edge as a new edge event. The bus write has to be timed against the synchroniser depth so that it commits exactly when the event is latched. A directed step places the clear one cycle after the second synchroniser flop captures the new level. A long random phase then mixes pin toggles with random configuration, pending and enable writes. That phase also covers mode changes while pins are moving and stale pending bits carried from an edge mode into a level mode.

// File: rtl/eit_pkg.sv
package eit_pkg;

  localparam int DATA_W   = 32;
  localparam int CODE_W   = 3;
  localparam int NIBBLE_W = 4;
  localparam int MAX_PINS = 6;

  typedef enum logic [1:0] {
    SLOT_CFG  = 2'd0,
    SLOT_AUX  = 2'd1,
    SLOT_PEND = 2'd2,
    SLOT_EN   = 2'd3
  } reg_slot_e;

  typedef enum logic [CODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_RSV4 = 3'd4,
    TRIG_HIGH = 3'd5,
    TRIG_LOW  = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_code_e;

endpackage

// File: rtl/eit_pin_sync.sv
module eit_pin_sync #(
  parameter int NUM_PINS = 6,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_sync
);

  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= pin_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/eit_trigger_detect.sv
module eit_trigger_detect
  import eit_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_sync,
  input  logic [NUM_PINS*CODE_W-1:0] cfg_codes,
  output logic [NUM_PINS-1:0]        edge_evt,
  output logic [NUM_PINS-1:0]        lvl_act
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_code_e code;
    logic       went_up;
    logic       went_down;

    assign code      = trig_code_e'(cfg_codes[i*CODE_W +: CODE_W]);
    assign went_up   = pin_sync[i] & ~prev_q[i];
    assign went_down = ~pin_sync[i] & prev_q[i];

    always_comb begin
      edge_evt[i] = 1'b0;
      lvl_act[i]  = 1'b0;
      unique case (code)
        TRIG_RISE: edge_evt[i] = went_up;
        TRIG_FALL: edge_evt[i] = went_down;
        TRIG_BOTH: edge_evt[i] = went_up | went_down;
        TRIG_HIGH: lvl_act[i]  = pin_sync[i];
        TRIG_LOW:  lvl_act[i]  = ~pin_sync[i];
        default: begin
          edge_evt[i] = 1'b0;
          lvl_act[i]  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/eit_regbank.sv
module eit_regbank
  import eit_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [1:0]                 bus_word,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        edge_evt,
  output logic [NUM_PINS*CODE_W-1:0] cfg_codes,
  output logic [NUM_PINS-1:0]        en_q,
  output logic [NUM_PINS-1:0]        pend_q
);

  localparam int CFG_BITS = NUM_PINS * NIBBLE_W;

  logic                wr_cfg, wr_pend, wr_en, rd_any;
  logic [CFG_BITS-1:0] cfg_view;

  assign wr_cfg  = bus_sel & bus_wr & (reg_slot_e'(bus_word) == SLOT_CFG);
  assign wr_pend = bus_sel & bus_wr & (reg_slot_e'(bus_word) == SLOT_PEND);
  assign wr_en   = bus_sel & bus_wr & (reg_slot_e'(bus_word) == SLOT_EN);
  assign rd_any  = bus_sel & ~bus_wr;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_codes[i*CODE_W +: CODE_W] <= '0;
      else if (wr_cfg) cfg_codes[i*CODE_W +: CODE_W] <= bus_wdata[i*NIBBLE_W +: CODE_W];
    end
    assign cfg_view[i*NIBBLE_W +: NIBBLE_W] = {1'b0, cfg_codes[i*CODE_W +: CODE_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (wr_pend ? (pend_q & bus_wdata[NUM_PINS-1:0]) : pend_q) | edge_evt;
      if (wr_en) en_q <= bus_wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (reg_slot_e'(bus_word))
        SLOT_CFG:  bus_rdata[CFG_BITS-1:0] = cfg_view;
        SLOT_AUX:  bus_rdata = '0;
        SLOT_PEND: bus_rdata[NUM_PINS-1:0] = pend_q;
        SLOT_EN:   bus_rdata[NUM_PINS-1:0] = en_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_BITS];

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import eit_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_word,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] irq_req
);

  if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
    $error("NUM_PINS out of range");
  end

  logic [NUM_PINS-1:0]        pin_sync;
  logic [NUM_PINS-1:0]        edge_evt;
  logic [NUM_PINS-1:0]        lvl_act;
  logic [NUM_PINS-1:0]        pend_q;
  logic [NUM_PINS-1:0]        en_q;
  logic [NUM_PINS*CODE_W-1:0] cfg_codes;

  eit_pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  eit_trigger_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .cfg_codes (cfg_codes),
    .edge_evt  (edge_evt),
    .lvl_act   (lvl_act)
  );

  eit_regbank #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .edge_evt  (edge_evt),
    .cfg_codes (cfg_codes),
    .en_q      (en_q),
    .pend_q    (pend_q)
  );

  assign irq_req = en_q & (pend_q | lvl_act);

endmodule

// File: rtl/eit_checker.sv
module eit_checker #(
  parameter int NUM_PINS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [1:0]            bus_word,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   irq_req,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [NUM_PINS-1:0]   pend_q,
  input logic [NUM_PINS-1:0]   edge_evt,
  input logic [NUM_PINS*3-1:0] cfg_codes
);

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_q) == '0);

  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_evt) |=> ((pend_q & $past(edge_evt)) == $past(edge_evt)));

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_word == 2'd2) |=>
      ((pend_q & ~$past(bus_wdata[NUM_PINS-1:0]) & ~$past(edge_evt)) == '0));

  // R5 / R6: pending bits rise only from an edge event
  assert_pend_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(edge_evt)) == '0);

  assert_aux_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_word == 2'd1) |-> (bus_rdata == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    logic [2:0] code;
    assign code = cfg_codes[i*3 +: 3];
    assert_no_edge_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'd0 || code == 3'd4 || code == 3'd5 || code == 3'd6 || code == 3'd7)
        |-> !edge_evt[i]);
  end

endmodule

bind ext_irq_trigger eit_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_word  (bus_word),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .edge_evt  (edge_evt),
  .cfg_codes (cfg_codes)
);

// File: tb/sim_ext_irq_trigger.sv
`timescale 1ns/1ps
module sim_ext_irq_trigger;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_word = 2'd0;
  logic [31:0]   bus_wdata = 32'd0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_irq_trigger #(.NUM_PINS(NP), .SYNC_STAGES(2)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pins),
    .irq_req   (irq_req)
  );

  // Reference model built from the requirements
  logic [NP-1:0] m_s1, m_s2, m_prev, m_pend, m_en;
  logic [2:0]    m_code [NP];

  function automatic logic [NP-1:0] f_evt(input logic [NP-1:0] s, input logic [NP-1:0] p);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      case (m_code[i])
        3'd1:    r[i] = s[i] & ~p[i];
        3'd2:    r[i] = ~s[i] & p[i];
        3'd3:    r[i] = s[i] ^ p[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] f_lvl(input logic [NP-1:0] s);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      r[i] = (m_code[i] == 3'd5) ? s[i] : (m_code[i] == 3'd6) ? ~s[i] : 1'b0;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_en <= '0;
      for (int i = 0; i < NP; i++) m_code[i] <= 3'd0;
    end else begin
      m_s1   <= pins;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_pend <= ((bus_sel && bus_wr && bus_word == 2'd2) ? (m_pend & bus_wdata[NP-1:0]) : m_pend)
                | f_evt(m_s2, m_prev);
      if (bus_sel && bus_wr && bus_word == 2'd3) m_en <= bus_wdata[NP-1:0];
      if (bus_sel && bus_wr && bus_word == 2'd0)
        for (int i = 0; i < NP; i++) m_code[i] <= bus_wdata[i*4 +: 3];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] w, input logic [31:0] exp);
    logic [31:0] d;
    rd(w, d);
    check(req, d, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_rd("R1 cfg", 2'd0, 32'h0);
    chk_rd("R1 aux", 2'd1, 32'h0);
    chk_rd("R1 pend", 2'd2, 32'h0);
    chk_rd("R1 en", 2'd3, 32'h0);
    check("R1 irq", 32'(irq_req), 32'h0);

    // R6 bring-up of pin 0 in low-level mode
    wr(2'd0, 32'h6);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h1);
    idle(1);
    check("R6 low active", 32'(irq_req), 32'h01);
    pins[0] = 1'b1; idle(3);
    check("R6 low released", 32'(irq_req), 32'h00);
    chk_rd("R6 no latch", 2'd2, 32'h0);

    wr(2'd0, 32'h0005_3216);
    wr(2'd3, 32'h3F);

    // R2 rising
    pins[1] = 1'b1; idle(3);
    chk_rd("R2 pend", 2'd2, 32'h02);
    check("R2 irq", 32'(irq_req), 32'h02);
    pins[1] = 1'b0; idle(3);
    chk_rd("R2 held", 2'd2, 32'h02);

    // R8 write-one keeps, write-zero clears
    wr(2'd2, 32'h3F);
    chk_rd("R8 keep", 2'd2, 32'h02);
    wr(2'd2, 32'h3D);
    chk_rd("R8 clear", 2'd2, 32'h00);
    check("R8 irq low", 32'(irq_req), 32'h0);

    // R3 falling
    pins[2] = 1'b1; idle(3);
    chk_rd("R3 rise ignored", 2'd2, 32'h0);
    pins[2] = 1'b0; idle(3);
    chk_rd("R3 fall", 2'd2, 32'h04);
    wr(2'd2, 32'h0);

    // R4 both
    pins[3] = 1'b1; idle(3);
    chk_rd("R4 rise", 2'd2, 32'h08);
    wr(2'd2, 32'h0);
    pins[3] = 1'b0; idle(3);
    chk_rd("R4 fall", 2'd2, 32'h08);
    wr(2'd2, 32'h0);

    // R5 high level
    pins[4] = 1'b1; idle(3);
    check("R5 high active", 32'(irq_req), 32'h10);
    chk_rd("R5 no latch", 2'd2, 32'h0);
    pins[4] = 1'b0; idle(3);
    check("R5 released", 32'(irq_req), 32'h0);

    // R7 idle codes 0, 4, 7 on pin 5
    foreach (m_code[k]) begin end
    for (int c = 0; c < 3; c++) begin
      wr(2'd0, (c == 0) ? 32'h0005_3216 : (c == 1) ? 32'h0045_3216 : 32'h0075_3216);
      pins[5] = 1'b1; idle(3);
      check("R7 irq high pin", 32'(irq_req), 32'h0);
      pins[5] = 1'b0; idle(3);
      chk_rd("R7 pend", 2'd2, 32'h0);
      check("R7 irq", 32'(irq_req), 32'h0);
    end
    wr(2'd0, 32'h0005_3216);

    // R9 enable gating
    wr(2'd3, 32'h3D);
    pins[1] = 1'b1; idle(3);
    chk_rd("R9 latched while disabled", 2'd2, 32'h02);
    check("R9 gated", 32'(irq_req), 32'h0);
    wr(2'd3, 32'h3F);
    check("R9 enabled", 32'(irq_req), 32'h02);
    pins[1] = 1'b0;
    wr(2'd2, 32'h0);
    idle(3);

    // R8 event and clear on the same edge
    pins[1] = 1'b1;
    idle(2);
    wr(2'd2, 32'h0);
    chk_rd("R8 event wins", 2'd2, 32'h02);
    pins[1] = 1'b0;
    wr(2'd2, 32'h0);
    idle(3);

    // R10 spare word
    wr(2'd1, 32'hFFFF_FFFF);
    chk_rd("R10 aux", 2'd1, 32'h0);
    chk_rd("R10 cfg", 2'd0, 32'h0005_3216);
    chk_rd("R10 en", 2'd3, 32'h3F);

    // R11 field packing
    wr(2'd0, 32'hFFFF_FFFF);
    chk_rd("R11 cfg mask", 2'd0, 32'h0077_7777);
    wr(2'd0, 32'h0005_3216);
    idle(3);

    // Random phase against the model (R2-R9)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      int op;
      check("R9 random irq", 32'(irq_req), 32'(m_en & (m_pend | f_lvl(m_s2))));
      if ($urandom_range(0, 3) == 0) pins = pins ^ NP'(1 << $urandom_range(0, NP-1));
      op = int'($urandom_range(0, 99));
      if (op < 5) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 2'd0; bus_wdata = $urandom;
      end else if (op < 20) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 2'd2; bus_wdata = $urandom;
      end else if (op < 25) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = 2'd3; bus_wdata = $urandom;
      end else begin
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = 2'd2;
        #1 d = bus_rdata;
        check("R8 random pend", d, 32'(m_pend));
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end

    done = 1'b1;
    finish_run();
  end

endmodule